// File: doc/BRIEF.md
# Programmable Shift-Add FIR Filter

This block is a direct-form FIR filter built without multipliers. Each new sample enters a tapped delay line. Every tap has a short list of signed power-of-two terms. Each term forms its share of the tap product with one barrel shift of the tap sample and then an add or a subtract. The term list is held in registers and can be rewritten at any time through a write port, so the filter response can change while the block runs.

Each term has its own cell, and all the cells are identical. The cell products feed a registered binary adder tree. The last stage of the tree rounds the sum to the output scale, clamps it to the output range and registers it. The block accepts one sample per clock and returns one filtered sample for each accepted sample, after a fixed latency.

With the default parameters there are 8 taps, 2 terms per tap, 12-bit signed samples, a 16-bit signed result and 8 fractional bits dropped at the output.

Top module: `sop_fir`

## Requirements
- R1: Direct form. The unscaled sum is y = sum over taps j of c_j * x[n-j]. Here x[n] is the sample accepted at the current clock, and x[n-j] are earlier accepted samples. The delay line advances only on clocks where in_valid is high, so idle cycles do not shift it.
- R2: Term word encoding is coef_word[5] = enable, coef_word[4] = subtract, coef_word[3:0] = shift amount (0 to 15). Coefficient c_j is the sum over the enabled terms of tap j of +2^shift, or -2^shift when subtract is 1.
- R3: A term with enable 0 contributes nothing, whatever its subtract bit and shift amount are.
- R4: When coef_we is high at a clock edge, term coef_term of tap coef_tap takes coef_word at that edge. A sample accepted at the same edge is still filtered with the old term. The next sample uses the new one.
- R5: When in_valid is high at edge k, out_valid is high for exactly one cycle, after edge k+5 (latency 1 + ceil(log2(8*2)) = 5 clocks). Back-to-back samples give back-to-back results, and out_valid never rises without a matching input.
- R6: Rounding is round-half-up at bit 8: out = floor((y + 128) / 256). For example, y = -128 gives 0 and y = 128 gives 1.
- R7: A rounded value above 32767 gives out_data = 32767. A rounded value below -32768 gives out_data = -32768.
- R8: Synchronous reset clears the delay line, all pipeline stages and all terms. After reset, out_data is 0 and out_valid is 0, and samples give 0 until terms are written.
- R9: out_data holds its last value on cycles where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 12 | Signed input sample |
| coef_we | input | 1 | Term write enable |
| coef_tap | input | 3 | Tap index of the term to write |
| coef_term | input | 1 | Term index within the tap |
| coef_word | input | 6 | Term word {enable, subtract, shift[3:0]} |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Signed, rounded, saturated result |

## Verification
A term stored under the wrong address, or with its sign or shift decoded wrongly, changes the scaled output of the next sample that reaches that tap. This shows at out_data five clocks after that sample is accepted. A delay line that slips on idle cycles shows the same way, once a later sample meets the wrong history. A valid pipeline that is too long or too short moves the out_valid pulse away from its fifth clock, and the exact-cycle check catches this on the first sample. Rounding and clamping errors only appear for boundary sums, so exact half-LSB values and full-scale inputs are driven on purpose.

// File: rtl/sop_fir_pkg.sv
package sop_fir_pkg;

  // Control bits that sit above the shift field inside one term word.
  localparam int TERM_CTRL_W  = 2;
  localparam int TERM_EN_OFS  = 1;
  localparam int TERM_NEG_OFS = 0;

  // Clocks from an accepted sample to its result:
  // one product stage, then one stage for each adder-tree level.
  function automatic int pipe_depth(int n_leaves);
    return 1 + $clog2(n_leaves);
  endfunction

endpackage

// File: rtl/sop_term_cell.sv
module sop_term_cell #(
  parameter int DW = 12,
  parameter int SW = 4,
  parameter int PW = DW + (1 << SW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] tap,
  input  logic [SW+1:0]        term,
  output logic signed [PW-1:0] prod
);
  localparam int TW = SW + sop_fir_pkg::TERM_CTRL_W;

  // One signed power-of-two term applied to a tap sample.
  function automatic logic signed [PW-1:0] apply_term(
    input logic signed [DW-1:0] s,
    input logic [TW-1:0]        t
  );
    logic signed [PW-1:0] m;
    m = PW'(s) <<< t[SW-1:0];
    if (!t[SW + sop_fir_pkg::TERM_EN_OFS]) return '0;
    return t[SW + sop_fir_pkg::TERM_NEG_OFS] ? -m : m;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= apply_term(tap, term);
  end
endmodule

// File: rtl/sop_term_bank.sv
module sop_term_bank #(
  parameter int N    = 8,
  parameter int K    = 2,
  parameter int TW   = 6,
  parameter int TAPW = 3,
  parameter int TIW  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [TAPW-1:0] tap_idx,
  input  logic [TIW-1:0]  term_idx,
  input  logic [TW-1:0]   word,
  output logic [TW-1:0]   terms [N*K]
);
  localparam int NK = N * K;

  int addr;
  always_comb addr = int'(tap_idx) * K + int'(term_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NK; i++) terms[i] <= '0;
    end else if (we && addr < NK) begin
      terms[addr] <= word;
    end
  end
endmodule

// File: rtl/sop_add_tree.sv
module sop_add_tree #(
  parameter int NL = 16,
  parameter int PW = 28,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [PW-1:0] leaf [NL],
  output logic signed [AW-1:0] left,
  output logic signed [AW-1:0] right
);
  // Heap numbering: the root (node 1) is formed by the caller.
  // Nodes 2..NL-1 are registered here, and leaves sit at NL..2*NL-1.
  logic signed [AW-1:0] node_r [2:NL-1];
  logic signed [AW-1:0] all_n  [2:2*NL-1];

  always_comb begin
    for (int n = 2; n < NL; n++) all_n[n] = node_r[n];
    for (int i = 0; i < NL; i++) all_n[NL+i] = AW'(leaf[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 2; n < NL; n++) node_r[n] <= '0;
    end else begin
      for (int n = 2; n < NL; n++) node_r[n] <= all_n[2*n] + all_n[2*n+1];
    end
  end

  assign left  = all_n[2];
  assign right = all_n[3];
endmodule

// File: rtl/sop_fir.sv
module sop_fir #(
  parameter int N  = 8,
  parameter int K  = 2,
  parameter int DW = 12,
  parameter int OW = 16,
  parameter int SW = 4,
  parameter int RS = 8,
  localparam int TAPW = (N > 1) ? $clog2(N) : 1,
  localparam int TIW  = (K > 1) ? $clog2(K) : 1,
  localparam int TW   = SW + sop_fir_pkg::TERM_CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic                 coef_we,
  input  logic [TAPW-1:0]      coef_tap,
  input  logic [TIW-1:0]       coef_term,
  input  logic [TW-1:0]        coef_word,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int NK  = N * K;
  localparam int LV  = $clog2(NK);
  localparam int NL  = 1 << LV;
  localparam int PW  = DW + (1 << SW);
  localparam int AW  = PW + LV;
  localparam int LAT = sop_fir_pkg::pipe_depth(NK);
  localparam logic signed [AW:0] OUT_MAX = {{(AW+2-OW){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW:0] OUT_MIN = {{(AW+2-OW){1'b1}}, {(OW-1){1'b0}}};

  // Round half up at bit RS. One spare bit keeps the added half from overflowing.
  function automatic logic signed [AW:0] round_half_up(input logic signed [AW-1:0] v);
    logic signed [AW:0] w;
    logic signed [AW:0] half;
    w    = {v[AW-1], v};
    half = (AW+1)'(1) <<< RS;
    half = half >>> 1;
    return (w + half) >>> RS;
  endfunction

  // ---- term storage
  logic [TW-1:0] terms [NK];
  sop_term_bank #(.N(N), .K(K), .TW(TW), .TAPW(TAPW), .TIW(TIW)) u_bank (
    .clk(clk), .rst(rst), .we(coef_we), .tap_idx(coef_tap),
    .term_idx(coef_term), .word(coef_word), .terms(terms)
  );

  // ---- delay line (moves only on accepted samples)
  logic signed [DW-1:0]   dly  [N-1];
  logic signed [DW-1:0]   taps [N];
  logic [(N-1)*DW-1:0]    dly_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N-1; j++) dly[j] <= '0;
    end else if (in_valid) begin
      dly[0] <= in_sample;
      for (int j = 1; j < N-1; j++) dly[j] <= dly[j-1];
    end
  end

  assign taps[0] = in_sample;
  generate
    for (genvar j = 1; j < N; j++) begin : g_tap
      assign taps[j] = dly[j-1];
      assign dly_flat[(j-1)*DW +: DW] = dly[j-1];
    end
  endgenerate

  // ---- term cells, one per (tap, term), padded to a power of two
  logic signed [PW-1:0] leaf [NL];
  generate
    for (genvar t = 0; t < N; t++) begin : g_t
      for (genvar k = 0; k < K; k++) begin : g_k
        sop_term_cell #(.DW(DW), .SW(SW), .PW(PW)) u_cell (
          .clk(clk), .rst(rst), .tap(taps[t]),
          .term(terms[t*K+k]), .prod(leaf[t*K+k])
        );
      end
    end
    for (genvar p = NK; p < NL; p++) begin : g_pad
      assign leaf[p] = '0;
    end
  endgenerate

  // ---- registered adder tree
  logic signed [AW-1:0] half_l, half_r;
  sop_add_tree #(.NL(NL), .PW(PW), .AW(AW)) u_tree (
    .clk(clk), .rst(rst), .leaf(leaf), .left(half_l), .right(half_r)
  );

  // ---- valid pipeline, one stage per register level before the output
  logic [LV-1:0] vpipe;
  logic          fin_valid;
  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
    end else begin
      vpipe[0] <= in_valid;
      for (int i = 1; i < LV; i++) vpipe[i] <= vpipe[i-1];
    end
  end
  assign fin_valid = vpipe[LV-1];

  // ---- root add, round, saturate, register
  logic signed [AW-1:0] root_sum;
  logic signed [AW:0]   rounded;
  logic                 sat_hi, sat_lo;

  assign root_sum = half_l + half_r;
  assign rounded  = round_half_up(root_sum);
  assign sat_hi   = rounded > OUT_MAX;
  assign sat_lo   = rounded < OUT_MIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fin_valid;
      if (fin_valid) begin
        if (sat_hi)      out_data <= OUT_MAX[OW-1:0];
        else if (sat_lo) out_data <= OUT_MIN[OW-1:0];
        else             out_data <= rounded[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/sop_fir_chk.sv
module sop_fir_chk #(
  parameter int OW   = 16,
  parameter int LAT  = 5,
  parameter int DLYW = 84
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 fin_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data,
  input logic                 sat_hi,
  input logic                 sat_lo,
  input logic [DLYW-1:0]      dly_flat
);
  localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

  // Cycles since reset, saturating, so $past never reaches before reset.
  logic [7:0] age;
  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 8'hFF) age <= age + 8'd1;
  end

  // R1
  dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dly_flat));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) >= LAT) |-> (out_valid == $past(in_valid, LAT)));

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_valid && sat_hi) |=> (out_data == MAXV));

  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_valid && sat_lo) |=> (out_data == MINV));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (out_data == '0 && !out_valid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

bind sop_fir sop_fir_chk #(.OW(OW), .LAT(LAT), .DLYW((N-1)*DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fin_valid(fin_valid),
  .out_valid(out_valid), .out_data(out_data), .sat_hi(sat_hi),
  .sat_lo(sat_lo), .dly_flat(dly_flat)
);

// File: tb/tb_sop_fir.sv
module tb_sop_fir;
  localparam int N = 8, K = 2, DW = 12, OW = 16, LAT = 5;

  // Table: back-to-back samples with c0 = +256 and c1 = -128.
  // Expected out = x[n] + floor((1 - x[n-1]) / 2).
  localparam int TAB_N = 8;
  localparam int TAB_X [TAB_N] = '{10, -5, 7, 0, 2047, -2048, 1, -1};
  localparam int TAB_Y [TAB_N] = '{10, -10, 10, -3, 2047, -3071, 1025, -1};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, coef_we = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic [2:0] coef_tap = '0;
  logic [0:0] coef_term = '0;
  logic [5:0] coef_word = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  always #5 clk = ~clk;

  sop_fir dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_tap(coef_tap), .coef_term(coef_term),
    .coef_word(coef_word), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench model state
  logic [5:0] mterm [N][K];
  int hist [N];
  longint exp_v [1024];
  int     exp_c [1024];
  string  exp_t [1024];
  int wr = 0, rd = 0;

  function automatic longint coef_of(int j);
    longint c = 0;
    for (int k = 0; k < K; k++)
      if (mterm[j][k][5])
        c += (mterm[j][k][4] ? -64'sd1 : 64'sd1) * (longint'(1) << mterm[j][k][3:0]);
    return c;
  endfunction

  function automatic longint model_out();
    longint y = 0, r, q;
    for (int j = 0; j < N; j++) y += coef_of(j) * longint'(hist[j]);
    r = y + 128;
    if (r >= 0) q = r / 256;
    else        q = -((-r + 255) / 256);
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Output monitor: exact cycle and value of every result
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (rd < wr) begin
          check(exp_t[rd], longint'(out_data), exp_v[rd]);
          check("R5 latency", longint'(cyc), longint'(exp_c[rd]));
          rd++;
        end else begin
          check("R5 out_valid without input", 1, 0);
        end
      end else if (rd < wr && exp_c[rd] <= cyc) begin
        check("R5 missing out_valid", 0, 1);
        rd++;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      coef_we  = 1'b0;
    end
  endtask

  task automatic wterm(input int t, input int k, input logic [5:0] w);
    @(negedge clk);
    in_valid  = 1'b0;
    coef_we   = 1'b1;
    coef_tap  = 3'(t);
    coef_term = 1'(k);
    coef_word = w;
    mterm[t][k] = w;
  endtask

  // Drive one sample; optionally write a term at the same edge.
  task automatic send(input int x, input string tag, input bit use_tab, input longint tabv,
                      input bit w, input int wt, input int wk, input logic [5:0] ww);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = x[DW-1:0];
    for (int j = N-1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    exp_v[wr] = use_tab ? tabv : model_out();
    exp_c[wr] = cyc + LAT;
    exp_t[wr] = tag;
    wr++;
    if (w) begin
      coef_we   = 1'b1;
      coef_tap  = 3'(wt);
      coef_term = 1'(wk);
      coef_word = ww;
      mterm[wt][wk] = ww;
    end else begin
      coef_we = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < N; j++) begin
      hist[j] = 0;
      for (int k = 0; k < K; k++) mterm[j][k] = '0;
    end
    rd = wr;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int j = 0; j < N; j++) begin
      hist[j] = 0;
      for (int k = 0; k < K; k++) mterm[j][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: outputs after reset
    check("R8 reset out_data", longint'(out_data), 0);
    check("R8 reset out_valid", longint'(out_valid), 0);

    // R8: terms are clear after reset, so samples give zero
    send(100, "R8 unloaded terms", 1, 0, 0, 0, 0, '0);
    send(-200, "R8 unloaded terms", 1, 0, 0, 0, 0, '0);
    idle(LAT + 2);
    do_reset();

    // R1 R2 R6 table: c0 = +2^8 (0x28), c1 = -2^7 (0x37)
    wterm(0, 0, 6'h28);
    wterm(1, 0, 6'h37);
    for (int i = 0; i < TAB_N; i++)
      send(TAB_X[i], "R1 R6 table vector", 1, longint'(TAB_Y[i]), 0, 0, 0, '0);
    idle(LAT + 2);

    // R6: half-LSB cases with c0 = 2^7 and every other term off
    wterm(1, 0, 6'h00);
    wterm(0, 0, 6'h27);
    send(1,  "R6 half up +0.5", 1, 1, 0, 0, 0, '0);
    send(-1, "R6 half up -0.5", 1, 0, 0, 0, 0, '0);
    send(3,  "R6 half up +1.5", 1, 2, 0, 0, 0, '0);
    send(-3, "R6 half up -1.5", 1, -1, 0, 0, 0, '0);
    idle(LAT + 2);

    // R7: c0 = 2^15 + 2^15
    wterm(0, 0, 6'h2F);
    wterm(0, 1, 6'h2F);
    send(2047,  "R7 clamp high", 1, 32767, 0, 0, 0, '0);
    send(-2048, "R7 clamp low", 1, -32768, 0, 0, 0, '0);
    send(1,     "R7 in range", 1, 256, 0, 0, 0, '0);
    idle(LAT + 2);

    // R3: disabled term with subtract and shift set is ignored
    wterm(0, 0, 6'h28);
    wterm(0, 1, 6'h13);
    send(5, "R3 disabled term", 1, 5, 0, 0, 0, '0);
    idle(LAT + 4);
    // R9: output holds while out_valid is low
    check("R9 hold", longint'(out_data), 5);

    // R4: write at the same edge as a sample
    send(9, "R4 old term at write edge", 1, 9, 1, 0, 1, 6'h28);
    send(9, "R4 new term after write", 1, 18, 0, 0, 0, '0);
    idle(LAT + 2);

    // R1 R2: all taps programmed, pseudo-random samples with idle gaps
    for (int t = 0; t < N; t++)
      for (int k = 0; k < K; k++)
        wterm(t, k, {(t == 5 && k == 1) ? 1'b0 : 1'b1, 1'((t + k) % 2), 4'((t*3 + k*5) % 12)});
    lf = 32'h1ACE5EED;
    for (int i = 0; i < 40; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      send(int'(lf[27:16]) - 2048, "R1 R2 model compare", 0, 0, 0, 0, 0, '0);
      if (i % 3 == 2) idle(1 + (i % 2));
    end
    idle(LAT + 2);

    // R8: reset during operation clears the terms
    do_reset();
    @(negedge clk);
    check("R8 mid-run reset out_data", longint'(out_data), 0);
    send(1234, "R8 terms cleared by reset", 1, 0, 0, 0, 0, '0);
    idle(LAT + 3);

    check("R5 all results returned", longint'(rd), longint'(wr));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule